// File: doc/BRIEF.md
# Scripted Event Playback Transmitter

This block replays stored test events onto one output channel. A private memory is split into four equal event buffers, and each memory word pairs a 4-bit control code with a data field. Every stored word is one of the following:

- a data word to send;
- a delay word that holds off the next read;
- a marker that closes the event.

The stored content therefore fixes both the values that leave the block and the spacing between them.

A host fills the memory through a simple write port. A trigger pulse carries a 2-bit buffer number, and the trigger enters a small pending queue. Whenever the playback engine is idle and the queue holds an entry, the engine takes that entry. It then walks the selected buffer from word 0, pushes data into an output FIFO and interprets the delay and stop codes. The output FIFO drives a valid/data/ready interface, which stands in for a serial line driver. Backpressure stalls both the reads and the delay counting.

Top module: `evt_playback_tx`

## Requirements
- R1: A host write stores `host_wdata` at `host_addr`. The word layout is: control code in the top 4 bits, data in the low DATA_W bits. The address layout is: upper 2 bits select the buffer, lower BUF_AW bits give the word index. Stored words survive reset.
- R2: Playback starts at word 0 of the buffer named by `trig_buf`. Data words use code 0 and are sent in address order. With `out_ready` high, the first data word (at index 0) shows on `out_valid` 3 cycles after the trigger edge. Consecutive data words leave 2 cycles apart.
- R3: A latency word (code 1) with count N placed before the first data word delays that word by N+2 cycles.
- R4: A gap word (code 2) with count G between two data words stretches their spacing from 2 to G+4 cycles.
- R5: An end word (code 8) stops playback and produces no output. Words stored after it are never sent.
- R6: An empty-event word (code 4) ends playback at once with no output, even when data words follow it. `busy` drops 3 cycles after the trigger edge when this word is at index 0.
- R7: A word with any other code is skipped without output and costs 2 cycles.
- R8: While `out_ready` is low, no word is lost and the head word holds steady. Reads stall when the output FIFO is full, and all words leave in order once `out_ready` rises.
- R9: A delay count pauses while the output FIFO is full, and resumes once a word has been taken.
- R10: Triggers that arrive during playback queue in order, up to PEND_DEPTH entries. A trigger that meets a full queue is dropped.
- R11: Reset clears `out_valid`, `busy`, the output FIFO and all queued triggers.
- R12: `busy` is high from the cycle after a queued trigger is taken until the stop word has been executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Memory write strobe |
| host_addr | input | BUF_AW+2 | Buffer number (upper 2 bits) and word index |
| host_wdata | input | DATA_W+4 | Control code (upper 4 bits) and data |
| trig | input | 1 | Trigger accept, one pulse per event |
| trig_buf | input | 2 | Buffer to play for this trigger |
| out_ready | input | 1 | Downstream can take a word |
| out_valid | output | 1 | Output FIFO holds a word |
| out_data | output | DATA_W | Head word of the output FIFO |
| busy | output | 1 | Playback engine is running |

## Verification
The hardest case to reach is a delay count that is in progress while the output FIFO is full. To get there, the bench holds `out_ready` low and plays an event that fills the FIFO with four data words and then places a gap word. The bench then releases `out_ready` at a known cycle. The arrival cycle of the last word shows whether the count paused for the whole stall. The bench also runs a sweep over every latency and gap count from 0 to 3, and it sends a burst of six triggers on consecutive cycles so that the pending queue overflows.

// File: rtl/evt_pb_pkg.sv
package evt_pb_pkg;
  localparam int CTRL_W = 4;

  localparam logic [CTRL_W-1:0] OP_DATA  = 4'h0;
  localparam logic [CTRL_W-1:0] OP_LAT   = 4'h1;
  localparam logic [CTRL_W-1:0] OP_GAP   = 4'h2;
  localparam logic [CTRL_W-1:0] OP_EMPTY = 4'h4;
  localparam logic [CTRL_W-1:0] OP_END   = 4'h8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_EXEC = 2'd2,
    ST_WAIT = 2'd3
  } seq_state_t;
endpackage

// File: rtl/evt_pb_ram.sv
module evt_pb_ram #(
  parameter int WORD_W = 20,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/evt_pb_fifo.sv
module evt_pb_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [AW:0]      cnt;
  logic             do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == (AW+1)'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/evt_pb_seq.sv
module evt_pb_seq
  import evt_pb_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BUF_AW = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     pend_empty,
  input  logic [1:0]               pend_buf,
  output logic                     pend_pop,
  output logic [BUF_AW+1:0]        raddr,
  input  logic [CTRL_W+DATA_W-1:0] rword,
  input  logic                     ofifo_full,
  output logic                     push,
  output logic [DATA_W-1:0]        push_data,
  output logic                     busy,
  output seq_state_t               state,
  output logic [DATA_W-1:0]        wait_cnt
);
  seq_state_t        state_q;
  logic [1:0]        buf_q;
  logic [BUF_AW-1:0] idx_q;
  logic [DATA_W-1:0] cnt_q;
  logic [CTRL_W-1:0] op;
  logic [DATA_W-1:0] arg;

  assign op        = rword[CTRL_W+DATA_W-1 -: CTRL_W];
  assign arg       = rword[DATA_W-1:0];
  assign raddr     = {buf_q, idx_q};
  assign pend_pop  = (state_q == ST_IDLE) && !pend_empty;
  assign push      = (state_q == ST_EXEC) && (op == OP_DATA) && !ofifo_full;
  assign push_data = arg;
  assign busy      = (state_q != ST_IDLE);
  assign state     = state_q;
  assign wait_cnt  = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      buf_q   <= '0;
      idx_q   <= '0;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (!pend_empty) begin
            buf_q   <= pend_buf;
            idx_q   <= '0;
            state_q <= ST_READ;
          end
        end
        ST_READ: state_q <= ST_EXEC;
        ST_EXEC: begin
          case (op)
            OP_DATA: begin
              if (!ofifo_full) begin
                idx_q   <= idx_q + 1'b1;
                state_q <= ST_READ;
              end
            end
            OP_LAT, OP_GAP: begin
              idx_q   <= idx_q + 1'b1;
              cnt_q   <= arg;
              state_q <= (arg == '0) ? ST_READ : ST_WAIT;
            end
            OP_EMPTY, OP_END: state_q <= ST_IDLE;
            default: begin
              idx_q   <= idx_q + 1'b1;
              state_q <= ST_READ;
            end
          endcase
        end
        ST_WAIT: begin
          if (!ofifo_full) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == DATA_W'(1)) state_q <= ST_READ;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/evt_playback_tx.sv
module evt_playback_tx
  import evt_pb_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int BUF_AW     = 4,
  parameter int OUT_DEPTH  = 4,
  parameter int PEND_DEPTH = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     host_we,
  input  logic [BUF_AW+1:0]        host_addr,
  input  logic [CTRL_W+DATA_W-1:0] host_wdata,
  input  logic                     trig,
  input  logic [1:0]               trig_buf,
  input  logic                     out_ready,
  output logic                     out_valid,
  output logic [DATA_W-1:0]        out_data,
  output logic                     busy
);
  localparam int WORD_W = CTRL_W + DATA_W;
  localparam int RAM_AW = BUF_AW + 2;

  logic [RAM_AW-1:0] ram_raddr;
  logic [WORD_W-1:0] ram_rdata;
  logic              pend_empty, pend_full, pend_pop;
  logic [1:0]        pend_buf;
  logic              o_empty, o_full, o_push;
  logic [DATA_W-1:0] o_din;
  seq_state_t        seq_state;
  logic [DATA_W-1:0] wait_cnt;

  evt_pb_ram #(.WORD_W(WORD_W), .ADDR_W(RAM_AW)) u_ram (
    .clk(clk), .we(host_we), .waddr(host_addr), .wdata(host_wdata),
    .raddr(ram_raddr), .rdata(ram_rdata)
  );

  evt_pb_fifo #(.WIDTH(2), .DEPTH(PEND_DEPTH)) u_pend (
    .clk(clk), .rst(rst), .push(trig), .din(trig_buf), .pop(pend_pop),
    .dout(pend_buf), .empty(pend_empty), .full(pend_full)
  );

  evt_pb_seq #(.DATA_W(DATA_W), .BUF_AW(BUF_AW)) u_seq (
    .clk(clk), .rst(rst),
    .pend_empty(pend_empty), .pend_buf(pend_buf), .pend_pop(pend_pop),
    .raddr(ram_raddr), .rword(ram_rdata),
    .ofifo_full(o_full), .push(o_push), .push_data(o_din),
    .busy(busy), .state(seq_state), .wait_cnt(wait_cnt)
  );

  evt_pb_fifo #(.WIDTH(DATA_W), .DEPTH(OUT_DEPTH)) u_out (
    .clk(clk), .rst(rst), .push(o_push), .din(o_din), .pop(out_ready),
    .dout(out_data), .empty(o_empty), .full(o_full)
  );

  assign out_valid = !o_empty;
endmodule

// File: rtl/evt_playback_chk.sv
module evt_playback_chk
  import evt_pb_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     out_valid,
  input logic                     out_ready,
  input logic [DATA_W-1:0]        out_data,
  input logic                     busy,
  input logic                     o_full,
  input logic                     pend_empty,
  input logic                     pend_full,
  input logic                     trig,
  input seq_state_t               state,
  input logic [DATA_W-1:0]        wait_cnt,
  input logic [CTRL_W+DATA_W-1:0] rword
);
  logic [CTRL_W-1:0] op;
  assign op = rword[CTRL_W+DATA_W-1 -: CTRL_W];

  // R8: a word not taken stays on the output unchanged
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R9: no delay progress while the output FIFO is full
  assert_pause_R9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT) && o_full |=> $stable(wait_cnt));

  // R5 and R6: stop codes return the engine to idle
  assert_stop_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EXEC) && ((op == OP_END) || (op == OP_EMPTY)) |=> !busy);

  // R10: a full queue that is not drained stays full after a trigger
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    pend_full && trig && busy |=> pend_full);

  // R11: reset clears the output side
  assert_reset_R11: assert property (@(posedge clk)
    rst |=> !out_valid && !busy);

  // R12: queued work starts on the next cycle when idle
  assert_start_R12: assert property (@(posedge clk) disable iff (rst)
    !busy && !pend_empty |=> busy);
endmodule

bind evt_playback_tx evt_playback_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .busy(busy), .o_full(o_full),
  .pend_empty(pend_empty), .pend_full(pend_full), .trig(trig),
  .state(seq_state), .wait_cnt(wait_cnt), .rword(ram_rdata)
);

// File: tb/evt_playback_tx_test.sv
`timescale 1ns/1ps
module evt_playback_tx_test;
  import evt_pb_pkg::*;
  localparam int DW = 16;
  localparam int BAW = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              host_we = 1'b0;
  logic [BAW+1:0]    host_addr = '0;
  logic [CTRL_W+DW-1:0] host_wdata = '0;
  logic              trig = 1'b0;
  logic [1:0]        trig_buf = 2'd0;
  logic              out_ready = 1'b1;
  logic              out_valid;
  logic [DW-1:0]     out_data;
  logic              busy;

  evt_playback_tx #(.DATA_W(DW), .BUF_AW(BAW), .OUT_DEPTH(4), .PEND_DEPTH(4)) uut (
    .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .trig(trig), .trig_buf(trig_buf),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data), .busy(busy)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [DW-1:0] rec_d [32];
  int            rec_c [32];
  int            nrec = 0;

  always @(negedge clk) begin
    #1;
    if (out_valid && out_ready) begin
      if (nrec < 32) begin
        rec_d[nrec] = out_data;
        rec_c[nrec] = cyc;
      end
      nrec++;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] b, input int idx, input logic [3:0] op, input logic [DW-1:0] d);
    @(negedge clk);
    host_we = 1'b1;
    host_addr = {b, idx[BAW-1:0]};
    host_wdata = {op, d};
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic fire(input logic [1:0] b, output int t0);
    @(negedge clk);
    trig = 1'b1;
    trig_buf = b;
    t0 = cyc + 1;
    @(negedge clk);
    trig = 1'b0;
  endtask

  task automatic wait_to(input int c);
    while (cyc < c) @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      finish_run();
    end
  end

  initial begin
    int t0;
    int r;
    repeat (3) @(negedge clk);
    #1;
    chk("R11 reset out_valid", out_valid, 0);
    chk("R11 reset busy", busy, 0);
    chk("R12 reset busy", busy, 0);
    @(negedge clk);
    rst = 1'b0;

    // R2 and R5: plain event with a word stored after the end mark
    wr(2'd0, 0, OP_DATA, 16'h00A1);
    wr(2'd0, 1, OP_DATA, 16'h00A2);
    wr(2'd0, 2, OP_DATA, 16'h00A3);
    wr(2'd0, 3, OP_END,  16'h0000);
    wr(2'd0, 4, OP_DATA, 16'h00EE);
    nrec = 0;
    fire(2'd0, t0);
    wait_to(t0 + 2);
    chk("R12 busy during playback", busy, 1);
    wait_to(t0 + 30);
    chk("R5 word count", nrec, 3);
    chk("R2 first cycle", rec_c[0], t0 + 3);
    chk("R2 second cycle", rec_c[1], t0 + 5);
    chk("R2 third cycle", rec_c[2], t0 + 7);
    chk("R2 data0", rec_d[0], 16'h00A1);
    chk("R2 data2", rec_d[2], 16'h00A3);
    chk("R12 idle after end", busy, 0);

    // R3 and R4: sweep of latency and gap counts
    for (int n = 0; n < 4; n++) begin
      for (int g = 0; g < 4; g++) begin
        wr(2'd1, 0, OP_LAT,  DW'(n));
        wr(2'd1, 1, OP_DATA, DW'(16'h0100 + n * 4 + g));
        wr(2'd1, 2, OP_GAP,  DW'(g));
        wr(2'd1, 3, OP_DATA, DW'(16'h0200 + n * 4 + g));
        wr(2'd1, 4, OP_END,  16'h0000);
        nrec = 0;
        fire(2'd1, t0);
        wait_to(t0 + 30);
        chk("R3 count", nrec, 2);
        chk("R3 latency", rec_c[0], t0 + 5 + n);
        chk("R4 gap spacing", rec_c[1] - rec_c[0], 4 + g);
        chk("R1 data from buffer 1", rec_d[1], 16'h0200 + n * 4 + g);
      end
    end

    // R6: empty event stops at once
    wr(2'd2, 0, OP_EMPTY, 16'h0000);
    wr(2'd2, 1, OP_DATA,  16'h0055);
    wr(2'd2, 2, OP_END,   16'h0000);
    nrec = 0;
    fire(2'd2, t0);
    wait_to(t0 + 2);
    chk("R6 busy before decode", busy, 1);
    wait_to(t0 + 3);
    chk("R6 busy drop", busy, 0);
    wait_to(t0 + 20);
    chk("R6 no output", nrec, 0);

    // R7: unknown code is skipped
    wr(2'd3, 0, OP_DATA, 16'h0031);
    wr(2'd3, 1, 4'h5,    16'h0077);
    wr(2'd3, 2, OP_DATA, 16'h0032);
    wr(2'd3, 3, OP_END,  16'h0000);
    nrec = 0;
    fire(2'd3, t0);
    wait_to(t0 + 30);
    chk("R7 count", nrec, 2);
    chk("R7 spacing", rec_c[1] - rec_c[0], 4);
    chk("R7 data", rec_d[1], 16'h0032);

    // R8: six words against a held-off output of depth four
    for (int i = 0; i < 6; i++) wr(2'd2, i, OP_DATA, DW'(16'h0061 + i));
    wr(2'd2, 6, OP_END, 16'h0000);
    out_ready = 1'b0;
    nrec = 0;
    fire(2'd2, t0);
    wait_to(t0 + 40);
    chk("R8 valid held", out_valid, 1);
    chk("R8 head held", out_data, 16'h0061);
    chk("R12 busy while stalled", busy, 1);
    @(negedge clk);
    out_ready = 1'b1;
    wait_to(t0 + 80);
    chk("R8 count", nrec, 6);
    for (int i = 0; i < 6; i++) chk("R8 order", rec_d[i], 16'h0061 + i);

    // R9: gap count paused while the FIFO is full
    for (int i = 0; i < 4; i++) wr(2'd0, i, OP_DATA, DW'(16'h0041 + i));
    wr(2'd0, 4, OP_GAP,  16'd5);
    wr(2'd0, 5, OP_DATA, 16'h0045);
    wr(2'd0, 6, OP_END,  16'h0000);
    out_ready = 1'b0;
    nrec = 0;
    fire(2'd0, t0);
    wait_to(t0 + 30);
    @(negedge clk);
    out_ready = 1'b1;
    r = cyc + 1;
    wait_to(r + 20);
    chk("R9 count", nrec, 5);
    chk("R9 first release", rec_c[0], r - 1);
    chk("R9 delayed word cycle", rec_c[4], r + 7);
    chk("R9 delayed word data", rec_d[4], 16'h0045);

    // R10: burst of six triggers, the last one meets a full queue
    for (int b = 0; b < 4; b++) begin
      wr(2'(b), 0, OP_DATA, DW'(16'h0010 + b));
      wr(2'(b), 1, OP_END,  16'h0000);
    end
    nrec = 0;
    @(negedge clk);
    trig = 1'b1;
    trig_buf = 2'd0;
    t0 = cyc + 1;
    for (int k = 1; k < 6; k++) begin
      @(negedge clk);
      trig_buf = 2'(k % 4);
    end
    @(negedge clk);
    trig = 1'b0;
    wait_to(t0 + 60);
    chk("R10 events played", nrec, 5);
    chk("R10 order 0", rec_d[0], 16'h0010);
    chk("R10 order 1", rec_d[1], 16'h0011);
    chk("R10 order 2", rec_d[2], 16'h0012);
    chk("R10 order 3", rec_d[3], 16'h0013);
    chk("R10 order 4", rec_d[4], 16'h0010);

    // R11: reset drops queued triggers, memory is kept
    @(negedge clk);
    trig = 1'b1;
    for (int k = 0; k < 4; k++) begin
      trig_buf = 2'(k);
      @(negedge clk);
    end
    trig = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    nrec = 0;
    #1;
    chk("R11 valid after reset", out_valid, 0);
    chk("R11 busy after reset", busy, 0);
    repeat (30) @(negedge clk);
    #1;
    chk("R11 queue cleared", nrec, 0);
    fire(2'd3, t0);
    wait_to(t0 + 20);
    chk("R11 memory kept count", nrec, 1);
    chk("R1 memory kept data", rec_d[0], 16'h0013);

    finish_run();
  end
endmodule